// File: doc/BRIEF.md
# Two-Wire Command Target for an Eight-Channel Acquisition Front End

This block is the serial target that lets a bus controller steer an eight-channel converter. It oversamples the bus clock and data lines from the system clock and cleans them up. It then recognises bus start and stop events and checks a 7-bit device address. On a write, it picks out one command byte. On a read, it returns the converter's latest result. The data line is open-drain, so the block never drives it high: it only raises an output-enable that pulls the line low.

After a write address is acknowledged, the command byte does not begin at a fixed bit. It begins at the first '1' the controller sends, so any leading zero bits are skipped. The command carries a channel number, a range select, a polarity select and a two-bit power mode. The block passes these fields to a conversion controller as registered outputs. It also gives single-cycle pulses when the polarity bit arrives, when a write address matches, and when a stop is seen. A read returns the 12-bit result left-justified across two bytes. The controller's acknowledge bits during a read are ignored.

Top module: `acq_i2c_target`

## Requirements
- R1: After reset, and after any later reset, `sda_oe_o` is 0, all command fields are 0 and no pulse is asserted.
- R2: The device address is 0101 in its upper four bits, followed by `addr_sel_i[2:0]`, with the R/W bit (0 = write) eighth. On a match, for either direction, `sda_oe_o` is 1 for the whole ninth clock, from the eighth falling SCL edge to the ninth.
- R3: On an address mismatch, `sda_oe_o` stays 0 and the block ignores every later bit until the next START. Command fields and pulses stay unchanged.
- R4: After an acknowledged write address, zero bits are skipped and the first '1' is taken as the command MSB. The fields are: bits 6:4 channel, bit 3 range, bit 2 bipolar, bits 1:0 power mode. After the eighth command bit the block pulls the ninth clock low. It ignores any further bytes until the next START or STOP.
- R5: On the sixth command bit (bipolar), `acq_o` pulses for one cycle, and channel, range and bipolar take their new values. The power mode updates only after the eighth bit.
- R6: `wr_match_o` pulses once for each matched write address. It does not pulse for a read or for a mismatch.
- R7: On a read, the result is captured at the end of the address acknowledge. The block then sends `result_i[11:4]`, then `result_i[3:0]` followed by four zeros, both MSB first. Each bit is changed only after a falling SCL edge. The ninth clock of each byte is released.
- R8: During a read, the controller's ACK or NACK is ignored. After the second byte, the same captured word repeats, starting again from the high byte.
- R9: Every STOP (SDA rising while SCL is high) gives one `stop_o` pulse, releases SDA and returns the block to idle.
- R10: A repeated START at any point releases SDA and restarts the address phase.
- R11: A low glitch of one system clock on SCL does not count as a bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 3 | Low three bits of the device address |
| result_i | input | RES_W (12) | Latest conversion result |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| chan_o | output | 3 | Selected channel |
| range_o | output | 1 | Range select bit |
| bipolar_o | output | 1 | Polarity select bit |
| pd_o | output | 2 | Power mode field |
| acq_o | output | 1 | Pulse when the polarity bit is latched |
| stop_o | output | 1 | Pulse on a STOP |
| wr_match_o | output | 1 | Pulse on a matched write address |

## Verification
The bench drives leading zero bits before a command. A design that aligned the command to the byte boundary would latch the wrong channel, and its acknowledge would land on the wrong clock. Reads alternate ACK and NACK from the controller and run past two bytes, and the result input changes mid-read. A design that stopped on NACK, did not wrap back to the high byte, or did not hold a snapshot of the word would show up as a wrong bit on the data line. The bench also checks repeated STARTs in the middle of an address, mismatched addresses followed by traffic, and a one-cycle SCL glitch. Each of these would otherwise shift the bit count, and the acknowledge would then appear in the wrong place.

// File: rtl/acq_i2c_pkg.sv
package acq_i2c_pkg;
  localparam logic [3:0] DEV_ID_HI = 4'b0101;
  localparam int TX_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACKW, ST_ADDR_ACK, ST_HUNT,
    ST_CMD, ST_CMD_ACKW, ST_CMD_ACK, ST_READ, ST_SKIP
  } st_e;

  typedef struct packed {
    logic [2:0] chan;
    logic       range_hi;
    logic       bipolar;
    logic [1:0] pd;
  } cmd_t;
endpackage

// File: rtl/acq_i2c_deglitch.sv
module acq_i2c_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(VOTE_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_LEN-1:0]    vote_q;
  logic [CNT_W-1:0]       ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_LEN; i++) ones = ones + CNT_W'(vote_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      vote_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      vote_q <= {vote_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= (ones > CNT_W'(VOTE_LEN / 2));
    end
  end
endmodule

// File: rtl/acq_i2c_events.sv
module acq_i2c_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign sda_lvl   = sda_f;
endmodule

// File: rtl/acq_i2c_engine.sv
module acq_i2c_engine
  import acq_i2c_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_bit,
  input  logic [2:0]       addr_sel,
  input  logic [RES_W-1:0] result,
  output logic             sda_oe,
  output cmd_t             cmd_q,
  output logic             acq_pulse,
  output logic             stop_pulse,
  output logic             wr_match_pulse
);
  localparam int PAD = TX_W - RES_W;

  st_e             state;
  logic [6:0]      shreg;
  logic [3:0]      bitcnt;
  logic            rw_q;
  logic            byte_sel;
  logic [TX_W-1:0] tx_q;
  logic [7:0]      cur_byte, other_byte;

  assign cur_byte   = byte_sel ? tx_q[7:0]  : tx_q[15:8];
  assign other_byte = byte_sel ? tx_q[15:8] : tx_q[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      shreg          <= '0;
      bitcnt         <= '0;
      rw_q           <= 1'b0;
      byte_sel       <= 1'b0;
      tx_q           <= '0;
      sda_oe         <= 1'b0;
      cmd_q          <= '0;
      acq_pulse      <= 1'b0;
      stop_pulse     <= 1'b0;
      wr_match_pulse <= 1'b0;
    end else begin
      acq_pulse      <= 1'b0;
      stop_pulse     <= 1'b0;
      wr_match_pulse <= 1'b0;
      if (stop_evt) begin
        state      <= ST_IDLE;
        sda_oe     <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (start_evt) begin
        state  <= ST_ADDR;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg  <= {shreg[5:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              if (shreg == {DEV_ID_HI, addr_sel}) begin
                rw_q           <= sda_bit;
                state          <= ST_ADDR_ACKW;
                wr_match_pulse <= ~sda_bit;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ADDR_ACK;
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rw_q) begin
              tx_q     <= TX_W'(result) << PAD;
              sda_oe   <= ~result[RES_W-1];
              byte_sel <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_READ;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_HUNT;
            end
          end
          ST_HUNT: if (scl_rise && sda_bit) begin
            shreg  <= 7'd1;
            bitcnt <= 4'd1;
            state  <= ST_CMD;
          end
          ST_CMD: if (scl_rise) begin
            shreg  <= {shreg[5:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd5) begin
              cmd_q.chan     <= shreg[3:1];
              cmd_q.range_hi <= shreg[0];
              cmd_q.bipolar  <= sda_bit;
              acq_pulse      <= 1'b1;
            end
            if (bitcnt == 4'd7) begin
              cmd_q.pd <= {shreg[0], sda_bit};
              state    <= ST_CMD_ACKW;
            end
          end
          ST_CMD_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_CMD_ACK;
          end
          ST_CMD_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_SKIP;
          end
          ST_READ: if (scl_fall) begin
            if (bitcnt < 4'd7) begin
              bitcnt <= bitcnt + 4'd1;
              sda_oe <= ~cur_byte[3'd6 - bitcnt[2:0]];
            end else if (bitcnt == 4'd7) begin
              bitcnt <= 4'd8;
              sda_oe <= 1'b0;
            end else begin
              bitcnt   <= '0;
              byte_sel <= ~byte_sel;
              sda_oe   <= ~other_byte[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_drive_states: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ADDR_ACK || state == ST_CMD_ACK || state == ST_READ));
  a_r3_skip_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP && !start_evt && !stop_evt) |=> (state == ST_SKIP && !sda_oe));
  a_r5_acq_single: assert property (@(posedge clk) disable iff (rst)
    acq_pulse |=> !acq_pulse);
  a_r6_match_then_ack: assert property (@(posedge clk) disable iff (rst)
    wr_match_pulse |-> state == ST_ADDR_ACKW);
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && !scl_fall && !start_evt && !stop_evt) |=> $stable(sda_oe));
  a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (state == ST_IDLE && !sda_oe && stop_pulse));
  a_r10_start_addr: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !stop_evt) |=> (state == ST_ADDR && bitcnt == 4'd0 && !sda_oe));
endmodule

// File: rtl/acq_i2c_target.sv
module acq_i2c_target
  import acq_i2c_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       addr_sel_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sda_oe_o,
  output logic [2:0]       chan_o,
  output logic             range_o,
  output logic             bipolar_o,
  output logic [1:0]       pd_o,
  output logic             acq_o,
  output logic             stop_o,
  output logic             wr_match_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, clean;
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
  cmd_t cmd_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    acq_i2c_deglitch #(.SYNC_STAGES(SYNC_STAGES), .VOTE_LEN(VOTE_LEN)) u_flt (
      .clk(clk), .rst(rst), .din(raw[g]), .dout(clean[g]));
  end

  acq_i2c_events u_evt (
    .clk(clk), .rst(rst), .scl_f(clean[0]), .sda_f(clean[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl));

  acq_i2c_engine #(.RES_W(RES_W)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_bit(sda_lvl),
    .addr_sel(addr_sel_i), .result(result_i), .sda_oe(sda_oe_o),
    .cmd_q(cmd_q), .acq_pulse(acq_o), .stop_pulse(stop_o),
    .wr_match_pulse(wr_match_o));

  assign chan_o    = cmd_q.chan;
  assign range_o   = cmd_q.range_hi;
  assign bipolar_o = cmd_q.bipolar;
  assign pd_o      = cmd_q.pd;
endmodule

// File: tb/acq_i2c_target_bench.sv
module acq_i2c_target_bench;
  localparam int Q      = 20;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] addr_sel = 3'b101;
  logic [11:0] res_in = '0;
  logic sda_oe, range_o, bipolar_o, acq, stp, wrm;
  logic [2:0] chan_o;
  logic [1:0] pd_o;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  acq_i2c_target u_acq_i2c_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .result_i(res_in), .sda_oe_o(sda_oe),
    .chan_o(chan_o), .range_o(range_o), .bipolar_o(bipolar_o), .pd_o(pd_o),
    .acq_o(acq), .stop_o(stp), .wr_match_o(wrm));

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";
  logic exp_oe = 1'b0;
  int settle = SETTLE;
  int n_acq = 0, n_stop = 0, n_wr = 0;
  int m_acq = 0, m_stop = 0, m_wr = 0;
  logic [2:0] m_chan = '0;
  logic m_rng = 0, m_bip = 0;
  logic [1:0] m_pd = '0;

  // every-clock comparison of the data-line drive against the model
  always @(negedge clk) begin
    if (rst) settle <= SETTLE;
    else begin
      if (acq) n_acq++;
      if (stp) n_stop++;
      if (wrm) n_wr++;
      if (settle > 0) settle--;
      else begin
        checks++;
        if (sda_oe !== exp_oe) begin
          errors++;
          $display("FAIL %s sda_oe actual %0b expected %0b at %0t", cur_req, sda_oe, exp_oe, $time);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_exp(input logic v);
    exp_oe = v;
    settle = SETTLE;
  endtask

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "chan", chan_o, m_chan);
    chk(req, "range", range_o, m_rng);
    chk(req, "bipolar", bipolar_o, m_bip);
    chk(req, "pd", pd_o, m_pd);
    chk(req, "acq count", n_acq, m_acq);
    chk(req, "wr_match count", n_wr, m_wr);
    chk(req, "stop count", n_stop, m_stop);
  endtask

  task automatic bus_clock(input logic m, input logic exp_next, input bit glitch = 0);
    sda_m = m;
    wait_clk(Q);
    scl_m = 1'b1;
    if (glitch) begin
      wait_clk(Q);
      scl_m = 1'b0;
      wait_clk(1);
      scl_m = 1'b1;
      wait_clk(Q - 1);
    end else wait_clk(2 * Q);
    scl_m = 1'b0;
    set_exp(exp_next);
    wait_clk(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    sda_m = 1'b0;
    set_exp(1'b0);
    wait_clk(Q);
    scl_m = 1'b0;
    wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    sda_m = 1'b1;
    set_exp(1'b0);
    m_stop++;
    wait_clk(Q);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] c, input int zeros,
                           input logic acked, input bit stop_after, input int glitch_at);
    bus_start();
    for (int i = 6; i >= 0; i--) bus_clock(a[i], 1'b0, (i == glitch_at));
    bus_clock(1'b0, acked);
    bus_clock(1'b1, 1'b0);
    if (acked) m_wr++;
    for (int z = 0; z < zeros; z++) bus_clock(1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      bus_clock(c[i], (i == 0) && acked);
      if (i == 2) begin
        if (acked) begin
          m_chan = c[6:4]; m_rng = c[3]; m_bip = c[2]; m_acq++;
        end
        // R5: fields before the power mode, power mode still old
        chk("R5", "chan mid-byte", chan_o, m_chan);
        chk("R5", "range mid-byte", range_o, m_rng);
        chk("R5", "bipolar mid-byte", bipolar_o, m_bip);
        chk("R5", "pd mid-byte", pd_o, m_pd);
        chk("R5", "acq mid-byte", n_acq, m_acq);
      end
    end
    bus_clock(1'b1, 1'b0);
    if (acked) m_pd = c[1:0];
    if (stop_after) bus_stop();
  endtask

  task automatic read_txn(input logic [6:0] a, input int nbytes, input logic [11:0] word,
                          input logic acked, input bit change_res);
    logic q[$];
    logic [7:0] b;
    res_in = word;
    for (int k = 0; k < nbytes; k++) begin
      b = (k % 2 == 0) ? word[11:4] : {word[3:0], 4'b0000};
      for (int j = 7; j >= 0; j--) q.push_back(b[j]);
    end
    bus_start();
    for (int i = 6; i >= 0; i--) bus_clock(a[i], 1'b0);
    bus_clock(1'b1, acked);
    bus_clock(1'b1, acked ? ~q[0] : 1'b0);
    for (int k = 0; k < nbytes; k++) begin
      for (int j = 0; j < 8; j++) begin
        int idx = k * 8 + j;
        bus_clock(1'b1, (j < 7 && acked) ? ~q[idx + 1] : 1'b0);
      end
      if (k == 0 && change_res) res_in = ~word;
      // R8: controller ACK/NACK alternates and has no effect
      if (k < nbytes - 1) bus_clock(k[0], acked ? ~q[(k + 1) * 8] : 1'b0);
    end
    bus_stop();
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3 * SETTLE);
    cur_req = "R1";
    chk("R1", "sda_oe after reset", sda_oe, 0);
    check_all("R1");

    cur_req = "R2";
    write_txn({4'b0101, 3'b101}, 8'b1_011_1_0_10, 0, 1'b1, 1, -1);
    check_all("R4");
    check_all("R6");
    check_all("R9");

    cur_req = "R4";
    write_txn({4'b0101, 3'b101}, 8'b1_110_0_1_01, 3, 1'b1, 1, -1);
    check_all("R4");

    cur_req = "R3";
    write_txn({4'b0101, 3'b100}, 8'b1_001_1_1_11, 0, 1'b0, 1, -1);
    check_all("R3");
    write_txn({4'b1101, 3'b101}, 8'b1_101_1_0_11, 1, 1'b0, 1, -1);
    check_all("R3");

    cur_req = "R7";
    read_txn({4'b0101, 3'b101}, 2, 12'hA5C, 1'b1, 0);
    check_all("R7");
    check_all("R6");

    cur_req = "R8";
    read_txn({4'b0101, 3'b101}, 4, 12'h3C9, 1'b1, 1);
    check_all("R8");

    cur_req = "R3";
    read_txn({4'b0111, 3'b101}, 2, 12'h0F0, 1'b0, 0);
    check_all("R3");

    cur_req = "R10";
    bus_start();
    for (int i = 0; i < 4; i++) bus_clock(i[0], 1'b0);
    write_txn({4'b0101, 3'b101}, 8'b1_010_1_1_00, 2, 1'b1, 0, -1);
    check_all("R10");
    read_txn({4'b0101, 3'b101}, 2, 12'h801, 1'b1, 0);
    check_all("R10");

    cur_req = "R11";
    write_txn({4'b0101, 3'b101}, 8'b1_100_0_0_11, 0, 1'b1, 1, 3);
    check_all("R11");

    cur_req = "R2";
    addr_sel = 3'b010;
    wait_clk(Q);
    write_txn({4'b0101, 3'b010}, 8'b1_111_1_1_10, 1, 1'b1, 1, -1);
    check_all("R2");

    cur_req = "R1";
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    m_chan = '0; m_rng = 0; m_bip = 0; m_pd = '0;
    set_exp(1'b0);
    wait_clk(3 * SETTLE);
    chk("R1", "sda_oe after second reset", sda_oe, 0);
    check_all("R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule